// File: doc/BRIEF.md
# Diode-Sensor Conversion Sequencer

This block is the control state machine in front of a single 8-bit converter that is shared by an on-chip temperature sensor and a remote diode-connected transistor. It steers the analog multiplexer, picks the bias current for the diode, pulses the converter start and waits for its done strobe. Each pass takes one local sample and two remote samples: the first at the high bias current and the second at the low one. It then publishes two temperature readings.

The remote reading is the high-current sample minus the low-current sample. The absolute diode voltage cancels in that difference. The difference is multiplied by a gain, shifted right and clamped into 8-bit two's complement at 1 degree per LSB. Two fault flags from the front end override the remote reading. A supply or ground short on the sensor pin forces +127. Two sensor pins tied together force 0. Both readings are written together at the end of a pass, so a reader never sees a mix of old and new results.

Top module: `diode_conv_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the machine in its idle state. In the first cycle after `rst` is released, `adc_start`, `mux_remote` and `bias_high` are 0, and both `local_temp` and `remote_temp` are 0.
- R2: The steps run in a fixed repeating order, one `adc_start` pulse of exactly one cycle per step. The steps are: local sample (`mux_remote`=0, `bias_high`=0), remote high-current sample (`mux_remote`=1, `bias_high`=1), remote low-current sample (`mux_remote`=1, `bias_high`=0), then a one-cycle commit step.
- R3: After each `adc_start`, the machine waits for `adc_done` for any number of cycles and issues no further `adc_start` until that done arrives. The `adc_data` value present with `adc_done` is the sample for that step.
- R4: `local_temp` takes the local sample unchanged, read as an 8-bit two's complement value.
- R5: With no fault flagged, `remote_temp` = ((hi − lo) × GAIN) arithmetically shifted right by SHIFT, rounding toward minus infinity. Here hi and lo are the two remote samples read as unsigned 8-bit values. The defaults are GAIN=3 and SHIFT=1.
- R6: A scaled remote value above +127 gives 0x7F, and one below −128 gives 0x80.
- R7: If `fault_rail` is high in the commit step, `remote_temp` becomes 0x7F. This takes priority over `fault_pins`.
- R8: If `fault_pins` is high and `fault_rail` is low in the commit step, `remote_temp` becomes 0x00.
- R9: `local_temp` and `remote_temp` change only at the clock edge that ends the commit step. That edge follows the low-current sample's `adc_done` by one cycle.
- R10: `mux_remote` and `bias_high` hold steady from each `adc_start` until the matching `adc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_data | input | 8 | Converter result |
| adc_done | input | 1 | Converter finished strobe |
| fault_rail | input | 1 | Remote sensor pin shorted to supply or ground |
| fault_pins | input | 1 | Remote sensor pins shorted together |
| adc_start | output | 1 | One-cycle conversion start pulse |
| mux_remote | output | 1 | Multiplexer select, 1 = remote diode |
| bias_high | output | 1 | Bias current select, 1 = high current |
| local_temp | output | 8 | Local reading, two's complement |
| remote_temp | output | 8 | Remote reading, two's complement |

## Verification
A stuck or skipped state shows up at the start of the next conversion as a wrong multiplexer or bias setting, or as a missing or doubled `adc_start`. A lost capture or a wrong subtraction order shows up one cycle after the third done strobe, as a wrong or sign-flipped remote reading. An early commit shows up as a reading that changes before the low-current sample has arrived. The bench models the converter and checks the select lines at every step and both readings at every commit.

// File: rtl/diode_pkg.sv
package diode_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOC_GO,
        ST_LOC_WAIT,
        ST_HI_GO,
        ST_HI_WAIT,
        ST_LO_GO,
        ST_LO_WAIT,
        ST_COMMIT
    } seq_state_t;

    typedef struct packed {
        logic start;
        logic sel_remote;
        logic bias_hi;
        logic grab_loc;
        logic grab_hi;
        logic grab_lo;
        logic commit;
    } seq_ctrl_t;

endpackage

// File: rtl/dcs_fsm.sv
module dcs_fsm
    import diode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adc_done,
    output seq_ctrl_t ctrl
);

    seq_state_t state;
    seq_state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     nxt = ST_LOC_GO;
            ST_LOC_GO:   nxt = ST_LOC_WAIT;
            ST_LOC_WAIT: if (adc_done) nxt = ST_HI_GO;
            ST_HI_GO:    nxt = ST_HI_WAIT;
            ST_HI_WAIT:  if (adc_done) nxt = ST_LO_GO;
            ST_LO_GO:    nxt = ST_LO_WAIT;
            ST_LO_WAIT:  if (adc_done) nxt = ST_COMMIT;
            ST_COMMIT:   nxt = ST_LOC_GO;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ctrl = '0;
        unique case (state)
            ST_IDLE: ;
            ST_LOC_GO: ctrl.start = 1'b1;
            ST_LOC_WAIT: ctrl.grab_loc = adc_done;
            ST_HI_GO: begin
                ctrl.start      = 1'b1;
                ctrl.sel_remote = 1'b1;
                ctrl.bias_hi    = 1'b1;
            end
            ST_HI_WAIT: begin
                ctrl.sel_remote = 1'b1;
                ctrl.bias_hi    = 1'b1;
                ctrl.grab_hi    = adc_done;
            end
            ST_LO_GO: begin
                ctrl.start      = 1'b1;
                ctrl.sel_remote = 1'b1;
            end
            ST_LO_WAIT: begin
                ctrl.sel_remote = 1'b1;
                ctrl.grab_lo    = adc_done;
            end
            ST_COMMIT: ctrl.commit = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/dcs_scaler.sv
module dcs_scaler #(
    parameter int DATA_W = 8,
    parameter int GAIN   = 3,
    parameter int SHIFT  = 1
) (
    input  logic [DATA_W-1:0]        hi,
    input  logic [DATA_W-1:0]        lo,
    output logic signed [DATA_W-1:0] temp
);

    localparam int DIFF_W = DATA_W + 2;
    localparam int GAIN_W = $clog2(GAIN + 1) + 1;
    localparam int PROD_W = DIFF_W + GAIN_W;
    localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] SAT_LO = -SAT_HI - PROD_W'(1);

    logic signed [DIFF_W-1:0] diff;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;

    assign diff = $signed({2'b00, hi}) - $signed({2'b00, lo});
    assign prod = PROD_W'(diff) * $signed(PROD_W'(GAIN));

    generate
        if (SHIFT == 0) begin : g_noshift
            assign shifted = prod;
        end else begin : g_shift
            assign shifted = prod >>> SHIFT;
        end
    endgenerate

    always_comb begin
        if (shifted > SAT_HI)      temp = SAT_HI[DATA_W-1:0];
        else if (shifted < SAT_LO) temp = SAT_LO[DATA_W-1:0];
        else                       temp = shifted[DATA_W-1:0];
    end

endmodule

// File: rtl/dcs_results.sv
module dcs_results
    import diode_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int GAIN   = 3,
    parameter int SHIFT  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_ctrl_t         ctrl,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              fault_rail,
    input  logic              fault_pins,
    output logic [DATA_W-1:0] local_temp,
    output logic [DATA_W-1:0] remote_temp
);

    localparam logic [DATA_W-1:0] RAIL_VAL = DATA_W'((2 ** (DATA_W - 1)) - 1);

    logic [DATA_W-1:0]        loc_s;
    logic [DATA_W-1:0]        hi_s;
    logic [DATA_W-1:0]        lo_s;
    logic signed [DATA_W-1:0] scaled;

    dcs_scaler #(.DATA_W(DATA_W), .GAIN(GAIN), .SHIFT(SHIFT)) u_scale (
        .hi   (hi_s),
        .lo   (lo_s),
        .temp (scaled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            loc_s       <= '0;
            hi_s        <= '0;
            lo_s        <= '0;
            local_temp  <= '0;
            remote_temp <= '0;
        end else begin
            if (ctrl.grab_loc) loc_s <= adc_data;
            if (ctrl.grab_hi)  hi_s  <= adc_data;
            if (ctrl.grab_lo)  lo_s  <= adc_data;
            if (ctrl.commit) begin
                local_temp <= loc_s;
                if (fault_rail)      remote_temp <= RAIL_VAL;
                else if (fault_pins) remote_temp <= '0;
                else                 remote_temp <= scaled;
            end
        end
    end

endmodule

// File: rtl/diode_conv_seq.sv
module diode_conv_seq
    import diode_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int GAIN   = 3,
    parameter int SHIFT  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              adc_done,
    input  logic              fault_rail,
    input  logic              fault_pins,
    output logic              adc_start,
    output logic              mux_remote,
    output logic              bias_high,
    output logic [DATA_W-1:0] local_temp,
    output logic [DATA_W-1:0] remote_temp
);

    seq_ctrl_t ctrl;

    dcs_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .adc_done (adc_done),
        .ctrl     (ctrl)
    );

    dcs_results #(.DATA_W(DATA_W), .GAIN(GAIN), .SHIFT(SHIFT)) u_res (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctrl),
        .adc_data    (adc_data),
        .fault_rail  (fault_rail),
        .fault_pins  (fault_pins),
        .local_temp  (local_temp),
        .remote_temp (remote_temp)
    );

    assign adc_start  = ctrl.start;
    assign mux_remote = ctrl.sel_remote;
    assign bias_high  = ctrl.bias_hi;

endmodule

// File: rtl/diode_conv_seq_chk.sv
module diode_conv_seq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              adc_done,
    input logic              fault_rail,
    input logic              adc_start,
    input logic              mux_remote,
    input logic              bias_high,
    input logic [DATA_W-1:0] local_temp,
    input logic [DATA_W-1:0] remote_temp
);

    logic [1:0] since_rst;
    logic       busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
            busy      <= 1'b0;
        end else begin
            if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
            if (adc_start)     busy <= 1'b1;
            else if (adc_done) busy <= 1'b0;
        end
    end

    // R1: idle outputs and cleared readings right after reset
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd0) |-> (!adc_start && !mux_remote && !bias_high &&
                                 local_temp == '0 && remote_temp == '0));

    // R2: start strobe lasts exactly one cycle
    a_r2_start_pulse: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);

    // R3: no new start while a conversion is outstanding
    a_r3_no_restart: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> !busy);

    // R10: selects hold through the conversion
    a_r10_sel_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !adc_done) |=> ($stable(mux_remote) && $stable(bias_high)));

    // R9: readings change only two edges after a done strobe
    a_r9_commit_timing: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 &&
         (local_temp != $past(local_temp) || remote_temp != $past(remote_temp)))
        |-> $past(adc_done, 2));

    // R7: a rail short forces full scale
    a_r7_rail_value: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && remote_temp != $past(remote_temp) && $past(fault_rail))
        |-> (remote_temp == DATA_W'((2 ** (DATA_W - 1)) - 1)));

endmodule

bind diode_conv_seq diode_conv_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .adc_done    (adc_done),
    .fault_rail  (fault_rail),
    .adc_start   (adc_start),
    .mux_remote  (mux_remote),
    .bias_high   (bias_high),
    .local_temp  (local_temp),
    .remote_temp (remote_temp)
);

// File: tb/diode_conv_seq_bench.sv
`timescale 1ns/1ps
module diode_conv_seq_bench;

    localparam int GAIN  = 3;
    localparam int SHIFT = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] adc_data = '0;
    logic       adc_done = 1'b0;
    logic       fault_rail = 1'b0;
    logic       fault_pins = 1'b0;
    logic       adc_start;
    logic       mux_remote;
    logic       bias_high;
    logic [7:0] local_temp;
    logic [7:0] remote_temp;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    diode_conv_seq u_diode_conv_seq (
        .clk         (clk),
        .rst         (rst),
        .adc_data    (adc_data),
        .adc_done    (adc_done),
        .fault_rail  (fault_rail),
        .fault_pins  (fault_pins),
        .adc_start   (adc_start),
        .mux_remote  (mux_remote),
        .bias_high   (bias_high),
        .local_temp  (local_temp),
        .remote_temp (remote_temp)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act %0d cycles exp below 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_run = n_run + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    function automatic int exp_remote(input int hi, input int lo,
                                      input bit rail, input bit pins);
        int v;
        if (rail) return 127;
        if (pins) return 0;
        v = ((hi - lo) * GAIN) >>> SHIFT;
        if (v > 127)  v = 127;
        if (v < -128) v = -128;
        return v;
    endfunction

    // Wait for a start pulse, check selects, answer after delay cycles.
    task automatic convert(input int data, input int delay,
                           input bit exp_mux, input bit exp_bias);
        int guard = 0;
        while (!adc_start && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check("R2 start seen", int'(adc_start), 1);
        check("R2 mux select", int'(mux_remote), int'(exp_mux));
        check("R2 bias select", int'(bias_high), int'(exp_bias));
        @(negedge clk);
        check("R2 one-cycle start", int'(adc_start), 0);
        for (int i = 0; i < delay; i++) begin
            if (adc_start || mux_remote != exp_mux || bias_high != exp_bias)
                check("R3 R10 hold while waiting",
                      int'({adc_start, mux_remote, bias_high}),
                      int'({1'b0, exp_mux, exp_bias}));
            @(negedge clk);
        end
        adc_data = 8'(data);
        adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
        adc_data = 8'hAA;
    endtask

    task automatic run_pass(input string tag, input int loc, input int hi, input int lo,
                            input int delay, input bit rail, input bit pins);
        logic [7:0] old_l = local_temp;
        logic [7:0] old_r = remote_temp;
        fault_rail = rail;
        fault_pins = pins;
        convert(loc, delay, 1'b0, 1'b0);
        convert(hi, delay, 1'b1, 1'b1);
        check({"R9 local held mid-pass ", tag}, int'(local_temp), int'(old_l));
        check({"R9 remote held mid-pass ", tag}, int'(remote_temp), int'(old_r));
        convert(lo, 0, 1'b1, 1'b0);
        check({"R9 still held in commit step ", tag}, int'(remote_temp), int'(old_r));
        @(negedge clk);
        check({"R4 local ", tag}, int'($signed(local_temp)), int'($signed(8'(loc))));
        check({"R5 R6 R7 R8 remote ", tag}, int'($signed(remote_temp)),
              exp_remote(hi, lo, rail, pins));
        fault_rail = 1'b0;
        fault_pins = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b0;
        check("R1 start low", int'(adc_start), 0);
        check("R1 mux low", int'(mux_remote), 0);
        check("R1 bias low", int'(bias_high), 0);
        check("R1 local zero", int'(local_temp), 0);
        check("R1 remote zero", int'(remote_temp), 0);
    endtask

    task automatic t_basic();
        run_pass("basic", 25, 200, 180, 1, 0, 0);
        run_pass("negative local", 8'hF0, 60, 50, 2, 0, 0);
    endtask

    task automatic t_signs();
        run_pass("negative diff", 10, 100, 110, 0, 0, 0);
        run_pass("odd negative floor", 11, 100, 103, 1, 0, 0);
        run_pass("odd positive", 12, 103, 100, 1, 0, 0);
    endtask

    task automatic t_saturate();
        run_pass("R6 upper clamp", 30, 255, 0, 0, 0, 0);
        run_pass("R6 lower clamp", 31, 0, 255, 0, 0, 0);
        run_pass("R6 edge 127", 32, 85, 0, 0, 0, 0);
    endtask

    task automatic t_faults();
        run_pass("R7 rail", 40, 100, 100, 0, 1, 0);
        run_pass("R8 pins", 41, 200, 100, 0, 0, 1);
        run_pass("R7 rail over pins", 42, 0, 200, 0, 1, 1);
    endtask

    task automatic t_long_wait();
        run_pass("R3 long wait", 50, 140, 120, 40, 0, 0);
    endtask

    task automatic t_mid_reset();
        convert(7, 1, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-pass reset start", int'(adc_start), 0);
        check("R1 mid-pass reset mux", int'(mux_remote), 0);
        check("R1 mid-pass reset local", int'(local_temp), 0);
        check("R1 mid-pass reset remote", int'(remote_temp), 0);
        run_pass("after reset", 60, 90, 80, 1, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_signs();
        t_saturate();
        t_faults();
        t_long_wait();
        t_mid_reset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule